// File: doc/BRIEF.md
# OTG Hardware Assist Sequencer

This block takes three time-critical USB On-The-Go transitions out of software's hands, so that interrupt latency cannot break the millisecond windows the protocol demands. The first transition is an automatic port reset. It starts as soon as a device connects and ends with a port-enable-change event. The second is a session-request pulse on the data line. Software starts it with a single strobe, and the block times it and ends it without further action. The third is the handover during role negotiation: after the far side disconnects while the local host is suspended, the block turns on the D+ pull-up so the port becomes the peripheral.

All durations are counted in ticks of a 1 ms strobe input, `ms_tick`. Each assist has its own enable. Clearing an enable while its sequence runs stops that sequence at once and releases the output it drives. The three status flags are cleared by writing one to them. A new event in the same cycle as the write wins over the clear.

Top module: `otg_assist_seq`

## Requirements
- R1: When `en_auto_reset` is 1, a rising edge of `connect_i` drives `port_reset_o` to 1 in the next clock cycle, before any `ms_tick` arrives. This meets the 1 ms start window with no software command.
- R2: Every rising edge of `connect_i` sets `connect_flag_o` in the next cycle, whatever `en_auto_reset` is. While `en_auto_reset` is 0, a connect leaves `port_reset_o` at 0.
- R3: `port_reset_o` stays 1 until the RESET_TICKS-th `ms_tick` after it rose (default 10). At that edge it falls and `port_en_chg_o` is set. `port_change_irq_o` is the OR of `connect_flag_o` and `port_en_chg_o`.
- R4: A one-cycle `pulse_start` with `en_data_pulse` at 1 sets `pulse_status_o`, `pulse_start_bit_o` and `dp_pullup_o` in the next cycle. A `pulse_start` is ignored while `en_data_pulse` is 0 or while a pulse is already running.
- R5: The pulse ends on the PULSE_TICKS-th `ms_tick` after it started (default 7). At that edge both `pulse_status_o` and `pulse_start_bit_o` return to 0, so the pulse lasts between 6 and 7 ms, inside the 5 to 10 ms window.
- R6: The handover arms only when `en_handover`, `host_suspend_i` and `disconnect_i` are all 1 in the same cycle. Any two of them alone leave `dp_pullup_o` at 0, even across a tick.
- R7: Once the handover is armed, the next `ms_tick` turns `dp_pullup_o` on and sets `handover_flag_o`, even if suspend or disconnect has dropped in the meantime. The pull-up then stays on until `en_handover` is cleared, well inside the 3 ms limit.
- R8: Clearing an assist's enable while its sequence is armed or running releases that sequence's output in the next cycle and returns it to idle. No completion flag is set, whatever ticks follow.
- R9: Each flag (`connect_flag_o`, `port_en_chg_o`, `handover_flag_o`) clears in the cycle after a 1 on its clear input. When a new set event falls in the same cycle as the clear, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| en_auto_reset | input | 1 | Enable for the auto reset after connect |
| en_data_pulse | input | 1 | Enable for the timed data pulse |
| en_handover | input | 1 | Enable for the disconnect-to-pull-up handover |
| pulse_start | input | 1 | Write of 1 to the pulse start bit |
| connect_i | input | 1 | Device connect status level |
| disconnect_i | input | 1 | Device disconnect detected level |
| host_suspend_i | input | 1 | Host side is in suspend |
| clr_connect | input | 1 | Write-one-to-clear for the connect flag |
| clr_port_en_chg | input | 1 | Write-one-to-clear for the port enable change flag |
| clr_handover | input | 1 | Write-one-to-clear for the handover done flag |
| port_reset_o | output | 1 | Port reset drive |
| pulse_status_o | output | 1 | Data pulse in progress |
| pulse_start_bit_o | output | 1 | Start bit read-back; self-clears at pulse end |
| dp_pullup_o | output | 1 | D+ pull-up enable (data pulse or handover) |
| connect_flag_o | output | 1 | Connect status flag |
| port_en_chg_o | output | 1 | Port enable change flag |
| handover_flag_o | output | 1 | Handover completed flag |
| port_change_irq_o | output | 1 | Port change interrupt request |

## Verification
A table of input patterns runs the handover. Each row pairs enable, suspend, disconnect, tick and flag clear. The patterns include each two-of-three subset of conditions, a tick while armed after the conditions have dropped, an abort while armed, and a tick that coincides with a flag clear. Together they separate a correct three-way AND from a partial one, and tick-gated arming from arming that follows the live conditions. Directed sequences count ticks for the reset and the pulse up to one short of the end and then exactly to the end, which catches off-by-one lengths. They also connect with the assist disabled, re-connect during a flag clear, and drop enables mid-sequence, which separates abort from completion.

// File: rtl/otg_assist_pkg.sv
package otg_assist_pkg;

  typedef enum logic [1:0] {
    HO_IDLE   = 2'd0,
    HO_ARMED  = 2'd1,
    HO_PULLUP = 2'd2
  } ho_state_t;

  // Width of a counter that must hold values 0 .. n-1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Next value of a write-one-to-clear flag; a set event wins
  function automatic logic flag_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/otg_ms_window.sv
module otg_ms_window #(
  parameter int unsigned TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic start,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CW = otg_assist_pkg::cnt_width(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign done_o   = active_q & enable & tick & at_last;
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!enable) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      active_q <= start;
      cnt_q    <= '0;
    end else if (tick) begin
      if (at_last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Tick count never runs past the window length
  assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= LAST));
  // Completion releases the window
  assert_done_ends_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !active_o);
  // Dropped enable always leaves the window idle
  assert_abort_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active_o);
  // An accepted start opens the window in the next cycle
  assert_start_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && enable && !active_o) |=> active_o);

endmodule

// File: rtl/otg_handover_ctl.sv
module otg_handover_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic suspend,
  input  logic disconnect,
  output logic pullup_o,
  output logic done_o
);
  import otg_assist_pkg::*;

  ho_state_t state_q, state_d;
  logic      arm_cond;

  assign arm_cond = enable & suspend & disconnect;
  assign done_o   = (state_q == HO_ARMED) & enable & tick;
  assign pullup_o = (state_q == HO_PULLUP);

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = HO_IDLE;
    end else begin
      unique case (state_q)
        HO_IDLE:   if (arm_cond) state_d = HO_ARMED;
        HO_ARMED:  if (tick)     state_d = HO_PULLUP;
        HO_PULLUP: state_d = HO_PULLUP;
        default:   state_d = HO_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= HO_IDLE;
    else        state_q <= state_d;
  end

  // Arming needs all three conditions at once
  assert_arm_needs_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HO_IDLE && !arm_cond) |=> state_q == HO_IDLE);
  // Pull-up follows the first tick after arming
  assert_pullup_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> pullup_o);
  // Pull-up released when the enable is cleared
  assert_pullup_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pullup_o);

endmodule

// File: rtl/otg_w1c_flag.sv
module otg_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= otg_assist_pkg::flag_next(q, set, clr);
  end

  assign q_o = q;

  // A set event wins over a same-cycle clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q_o);
  // A clear with no set empties the flag
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q_o);

endmodule

// File: rtl/otg_assist_seq.sv
module otg_assist_seq #(
  parameter int unsigned RESET_TICKS = 10,
  parameter int unsigned PULSE_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic en_auto_reset,
  input  logic en_data_pulse,
  input  logic en_handover,
  input  logic pulse_start,
  input  logic connect_i,
  input  logic disconnect_i,
  input  logic host_suspend_i,
  input  logic clr_connect,
  input  logic clr_port_en_chg,
  input  logic clr_handover,
  output logic port_reset_o,
  output logic pulse_status_o,
  output logic pulse_start_bit_o,
  output logic dp_pullup_o,
  output logic connect_flag_o,
  output logic port_en_chg_o,
  output logic handover_flag_o,
  output logic port_change_irq_o
);
  localparam int unsigned NFLAG = 3;

  logic connect_q;
  logic conn_rise;
  logic rst_active, rst_done;
  logic pls_active, pls_done;
  logic ho_pullup, ho_done;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) connect_q <= 1'b0;
    else        connect_q <= connect_i;
  end
  assign conn_rise = connect_i & ~connect_q;

  otg_ms_window #(.TICKS(RESET_TICKS)) u_reset_win (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .enable(en_auto_reset),
    .start(conn_rise), .active_o(rst_active), .done_o(rst_done)
  );

  otg_ms_window #(.TICKS(PULSE_TICKS)) u_pulse_win (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .enable(en_data_pulse),
    .start(pulse_start), .active_o(pls_active), .done_o(pls_done)
  );

  otg_handover_ctl u_handover (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .enable(en_handover),
    .suspend(host_suspend_i), .disconnect(disconnect_i),
    .pullup_o(ho_pullup), .done_o(ho_done)
  );

  assign flag_set = {ho_done, rst_done, conn_rise};
  assign flag_clr = {clr_handover, clr_port_en_chg, clr_connect};

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    otg_w1c_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[gi]), .clr(flag_clr[gi]),
      .q_o(flag_q[gi])
    );
  end

  assign connect_flag_o    = flag_q[0];
  assign port_en_chg_o     = flag_q[1];
  assign handover_flag_o   = flag_q[2];
  assign port_change_irq_o = flag_q[0] | flag_q[1];

  assign port_reset_o      = rst_active;
  assign pulse_status_o    = pls_active;
  assign pulse_start_bit_o = pls_active;
  assign dp_pullup_o       = pls_active | ho_pullup;

  // Auto reset starts the cycle after a connect edge
  assert_reset_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_rise && en_auto_reset && !port_reset_o) |=> port_reset_o);
  // Connect edge always raises the connect flag
  assert_connect_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conn_rise |=> connect_flag_o);
  // Reset completion releases reset and raises the enable change
  assert_reset_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> (port_en_chg_o && !port_reset_o));
  // Pulse end clears status and start bit together
  assert_pulse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pls_done |=> (!pulse_status_o && !pulse_start_bit_o));
  // Abort of the reset sets no enable change
  assert_abort_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_auto_reset && !port_en_chg_o && !clr_port_en_chg) |=> !port_en_chg_o);

endmodule

// File: tb/otg_assist_seq_tb.sv
module otg_assist_seq_tb_top;
  localparam int unsigned RT = 10;
  localparam int unsigned PT = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 0, en_auto_reset = 0, en_data_pulse = 0, en_handover = 0;
  logic pulse_start = 0, connect_i = 0, disconnect_i = 0, host_suspend_i = 0;
  logic clr_connect = 0, clr_port_en_chg = 0, clr_handover = 0;
  logic port_reset_o, pulse_status_o, pulse_start_bit_o, dp_pullup_o;
  logic connect_flag_o, port_en_chg_o, handover_flag_o, port_change_irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  otg_assist_seq #(.RESET_TICKS(RT), .PULSE_TICKS(PT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .en_auto_reset(en_auto_reset), .en_data_pulse(en_data_pulse),
    .en_handover(en_handover), .pulse_start(pulse_start),
    .connect_i(connect_i), .disconnect_i(disconnect_i),
    .host_suspend_i(host_suspend_i), .clr_connect(clr_connect),
    .clr_port_en_chg(clr_port_en_chg), .clr_handover(clr_handover),
    .port_reset_o(port_reset_o), .pulse_status_o(pulse_status_o),
    .pulse_start_bit_o(pulse_start_bit_o), .dp_pullup_o(dp_pullup_o),
    .connect_flag_o(connect_flag_o), .port_en_chg_o(port_en_chg_o),
    .handover_flag_o(handover_flag_o), .port_change_irq_o(port_change_irq_o)
  );

  // Handover rows: {en, suspend, disconnect, tick, clr, exp_pullup, exp_flag}
  localparam logic [6:0] HO_TBL [13] = '{
    7'b1100_0_00, // R6 two of three: no disconnect
    7'b1011_0_00, // R6 no suspend, tick does nothing
    7'b0110_0_00, // R6 enable off
    7'b1110_0_00, // R6 all three: armed, output still off
    7'b1110_0_00, // R7 waiting for a tick
    7'b1001_0_11, // R7 tick after conditions dropped: pull-up and flag
    7'b1000_0_11, // R7 pull-up holds
    7'b0000_0_01, // R8 enable cleared: release, flag kept
    7'b1110_1_00, // R9 flag cleared, re-armed
    7'b0111_0_00, // R8 abort while armed: no flag on the tick
    7'b1110_0_00, // R6 armed again
    7'b1111_1_11, // R9 tick and clear together: set wins
    7'b0000_0_01  // R8 release
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    step();
    ms_tick = 1'b0;
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // Reset state
    check("R3", "reset: port_reset", port_reset_o, 1'b0);
    check("R4", "reset: pulse status", pulse_status_o, 1'b0);
    check("R9", "reset: flags", connect_flag_o | port_en_chg_o | handover_flag_o, 1'b0);

    // Table of handover patterns
    for (int i = 0; i < 13; i++) begin
      {en_handover, host_suspend_i, disconnect_i, ms_tick, clr_handover} = HO_TBL[i][6:2];
      step();
      ms_tick = 1'b0;
      clr_handover = 1'b0;
      check("R6/R7/R8/R9", $sformatf("row %0d pull-up", i), dp_pullup_o, HO_TBL[i][1]);
      check("R6/R7/R8/R9", $sformatf("row %0d flag", i), handover_flag_o, HO_TBL[i][0]);
    end
    {en_handover, host_suspend_i, disconnect_i} = 3'b000;
    clr_handover = 1'b1; step(); clr_handover = 1'b0;

    // R1, R3: auto reset
    en_auto_reset = 1'b1;
    connect_i = 1'b1;
    step();
    check("R1", "reset starts before any tick", port_reset_o, 1'b1);
    check("R2", "connect flag", connect_flag_o, 1'b1);
    for (int k = 0; k < RT - 1; k++) tick();
    check("R3", "reset held one tick short", port_reset_o, 1'b1);
    check("R3", "no enable change yet", port_en_chg_o, 1'b0);
    tick();
    check("R3", "reset released", port_reset_o, 1'b0);
    check("R3", "enable change set", port_en_chg_o, 1'b1);
    check("R3", "irq", port_change_irq_o, 1'b1);
    clr_connect = 1'b1; clr_port_en_chg = 1'b1;
    step();
    clr_connect = 1'b0; clr_port_en_chg = 1'b0;
    check("R9", "connect flag cleared", connect_flag_o, 1'b0);
    check("R9", "enable change cleared", port_en_chg_o, 1'b0);
    check("R3", "irq low", port_change_irq_o, 1'b0);

    // R9: reconnect during a clear, R8: abort of reset
    connect_i = 1'b0; step();
    connect_i = 1'b1; clr_connect = 1'b1;
    step();
    clr_connect = 1'b0;
    check("R9", "connect set wins over clear", connect_flag_o, 1'b1);
    check("R1", "reset restarted", port_reset_o, 1'b1);
    tick(); tick();
    en_auto_reset = 1'b0;
    step();
    check("R8", "reset aborted", port_reset_o, 1'b0);
    for (int k = 0; k < RT + 2; k++) tick();
    check("R8", "no enable change after abort", port_en_chg_o, 1'b0);
    check("R8", "reset stays off", port_reset_o, 1'b0);

    // R2: connect with assist disabled
    clr_connect = 1'b1; connect_i = 1'b0; step(); clr_connect = 1'b0;
    connect_i = 1'b1;
    step();
    check("R2", "flag with assist off", connect_flag_o, 1'b1);
    check("R2", "no reset with assist off", port_reset_o, 1'b0);

    // R4: start ignored when disabled
    pulse_start = 1'b1; step(); pulse_start = 1'b0;
    check("R4", "start ignored when disabled", pulse_status_o, 1'b0);
    check("R4", "start bit stays low", pulse_start_bit_o, 1'b0);

    // R4, R5: full pulse
    en_data_pulse = 1'b1;
    pulse_start = 1'b1; step(); pulse_start = 1'b0;
    check("R4", "pulse status", pulse_status_o, 1'b1);
    check("R4", "start bit", pulse_start_bit_o, 1'b1);
    check("R4", "pull-up during pulse", dp_pullup_o, 1'b1);
    for (int k = 0; k < PT - 1; k++) begin
      if (k == 2) begin
        pulse_start = 1'b1; step(); pulse_start = 1'b0;  // R4 restart ignored
      end
      tick();
    end
    check("R5", "pulse held one tick short", pulse_status_o, 1'b1);
    tick();
    check("R5", "pulse status cleared", pulse_status_o, 1'b0);
    check("R5", "start bit cleared", pulse_start_bit_o, 1'b0);
    check("R5", "pull-up off", dp_pullup_o, 1'b0);

    // R8: pulse abort
    pulse_start = 1'b1; step(); pulse_start = 1'b0;
    tick(); tick();
    en_data_pulse = 1'b0;
    step();
    check("R8", "pulse aborted", pulse_status_o, 1'b0);
    check("R8", "start bit after abort", pulse_start_bit_o, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule